// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag and state store of a set-associative cache. It keeps, for every way of every set, the line address held there, a permission state, a reservation owned by a context ID, and a recently-used bit for replacement. It holds no data. A controller sends it one operation per request. The operations are: look up a line, look up while ignoring permission, check a set for room, allocate, free, set a permission, probe for a replacement victim, and set, clear or test a reservation.

Every request is accepted in the cycle it is presented. The answer comes back on registered response outputs one cycle later. The answer carries hit, way, access grant, room, victim address and lock test result. A request that breaks the rules raises a sticky error flag and changes no state. The number of sets is capacity divided by ways divided by line size. The set index is read from a parameterised bit position of the line address.

Top module: `tagdir_top`

## Requirements
- R1: After reset every way is empty: lookups miss, every set reports room, and the error flag is 0.
- R2: The set is selected by address bits [IDX_LO +: log2(SETS)], where SETS = CAP_BYTES / WAYS / LINE_BYTES. Equal tags in different sets never alias. With the defaults, bits [7:4] select one of 16 sets.
- R3: Lookup (op 0) hits only when an occupied way holds the address and its permission is not NotPresent. Peek (op 1) reports any occupied way holding the address, whatever its permission. Permission codes: 0 empty, 1 NotPresent, 2 Invalid, 3 ReadOnly, 4 ReadWrite, 5 Busy.
- R4: A lookup grants access when the hit way is ReadWrite, or when it is ReadOnly and the kind is load (0) or instruction fetch (1). A store (2) to ReadOnly is refused. Invalid, Busy and misses are never granted.
- R5: Room check (op 2) is true when a way already holds the address, or when some way is empty or NotPresent.
- R6: Allocate (op 3) writes the lowest-numbered empty or NotPresent way. It sets that way to Invalid, releases its reservation, and returns the way.
- R7: Replacement uses one recently-used bit per way. A lookup hit sets the bit whether or not access is granted. An allocation sets it only when req_touch is 1. When setting a bit would fill the set, all other bits clear. The victim is the lowest way whose bit is clear.
- R8: Victim probe (op 5) on a set with no room returns the victim's stored address and way.
- R9: Free (op 4) empties the way holding a present line.
- R10: Lock set (op 7) records the context on a present line. Lock test (op 9) is true only when the line is owned by exactly that context. Lock clear (op 8) releases it.
- R11: Allocating a present line, allocating into a set without room, probing a set with room, free, lock or set-permission (op 6) on an absent line, and an opcode above 9 all set the sticky error flag and change no state.
- R12: req_ready is always 1, and rsp_valid is high exactly in the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_kind | input | 2 | Access kind: 0 load, 1 fetch, 2 store |
| req_perm | input | 3 | Permission for set-permission |
| req_ctx | input | CTX_W | Context ID for lock operations |
| req_touch | input | 1 | Allocation marks way recently used |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line found |
| rsp_way | output | log2(WAYS) | Way found, allocated or chosen as victim |
| rsp_grant | output | 1 | Lookup access granted |
| rsp_room | output | 1 | Set has room for the address |
| rsp_vaddr | output | ADDR_W | Victim line address |
| rsp_locked | output | 1 | Lock test result |
| err_flag | output | 1 | Sticky illegal-request flag |

## Verification
The bench reuses a NotPresent way and checks that allocation lands there rather than in a higher empty way. A design that treated NotPresent as occupied would pick the wrong way, and peek would still find the old line. It walks the recently-used bits until the set saturates, where a design that failed to collapse the bits would get stuck reporting no victim, or way 0 for the wrong reason. It checks that re-allocation drops an old reservation and resets permission to Invalid, so that a stale lock or grant would show up at once. Each illegal request is run from a fresh reset, and the state is read back afterwards, so a design that flagged the error but still wrote the state is caught.

// File: rtl/tagdir_pkg.sv
// Shared encodings for the tag directory.
// Assumes: permission and opcode values match the brief; they are part of the interface.
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_EMPTY   = 3'd0,
        PERM_NOTPRES = 3'd1,
        PERM_INVALID = 3'd2,
        PERM_RDONLY  = 3'd3,
        PERM_RDWR    = 3'd4,
        PERM_BUSY    = 3'd5
    } perm_e;

    typedef enum logic [3:0] {
        OP_LOOKUP  = 4'd0,
        OP_PEEK    = 4'd1,
        OP_ROOM    = 4'd2,
        OP_ALLOC   = 4'd3,
        OP_FREE    = 4'd4,
        OP_VICTIM  = 4'd5,
        OP_SETPERM = 4'd6,
        OP_LKSET   = 4'd7,
        OP_LKCLR   = 4'd8,
        OP_LKTEST  = 4'd9
    } op_e;

    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_FETCH = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;

endpackage

// File: rtl/tagdir_way_cmp.sv
// Compares a key against all ways of one set and encodes the results.
// Assumes: row_tag/row_perm are the selected set; "lowest way wins" on duplicates.
module tagdir_way_cmp
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [WAYS-1:0][ADDR_W-1:0]   row_tag,
    input  perm_e [WAYS-1:0]              row_perm,
    output logic                          match_any,
    output logic                          hit_any,
    output logic                          free_any,
    output logic [WAY_W-1:0]              match_way,
    output logic [WAY_W-1:0]              hit_way,
    output logic [WAY_W-1:0]              free_way
);
    logic [WAYS-1:0] match_v, hit_v, free_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // per-way classification of occupancy and tag equality
        assign match_v[w] = (row_perm[w] != PERM_EMPTY) && (row_tag[w] == key);
        assign hit_v[w]   = match_v[w] && (row_perm[w] != PERM_NOTPRES);
        assign free_v[w]  = (row_perm[w] == PERM_EMPTY) || (row_perm[w] == PERM_NOTPRES);
    end

    // lowest-index priority encoding of the three vectors
    always_comb begin
        match_way = '0;
        hit_way   = '0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_v[w]) match_way = WAY_W'(w);
            if (hit_v[w])   hit_way   = WAY_W'(w);
            if (free_v[w])  free_way  = WAY_W'(w);
        end
    end

    assign match_any = |match_v;
    assign hit_any   = |hit_v;
    assign free_any  = |free_v;

endmodule

// File: rtl/tagdir_nru.sv
// Recently-used bit per way, per set; chooses the lowest not-recently-used way.
// Assumes: at most one touch per cycle; bits saturate by clearing all but the touched way.
module tagdir_nru #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way
);
    logic [WAYS-1:0] bits_q [SETS];
    logic [WAYS-1:0] sel_bit, next_row, rd_row;

    assign sel_bit  = WAYS'(1) << touch_way;
    assign next_row = (&(bits_q[touch_set] | sel_bit)) ? sel_bit
                                                       : (bits_q[touch_set] | sel_bit);
    assign rd_row   = bits_q[rd_set];

    // update the recency row of the touched set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
        end else if (touch_en) begin
            bits_q[touch_set] <= next_row;
        end
    end

    // pick the lowest way whose bit is clear
    always_comb begin
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!rd_row[w]) victim_way = WAY_W'(w);
    end

    // R7
    touched_way_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && rd_set == touch_set) |=> (rd_set != $past(touch_set)) ||
                                               (victim_way != $past(touch_way)));

endmodule

// File: rtl/tagdir_top.sv
// Set-associative tag directory: address, permission, reservation and recency per way.
// Assumes: addresses are line aligned; one request per cycle, answered the next cycle;
// illegal requests only raise the sticky error flag.
module tagdir_top
    import tagdir_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CAP_BYTES  = 1024,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int IDX_LO     = 4,
    parameter int CTX_W      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [3:0]               req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_kind,
    input  logic [2:0]               req_perm,
    input  logic [CTX_W-1:0]         req_ctx,
    input  logic                     req_touch,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [$clog2(WAYS)-1:0]  rsp_way,
    output logic                     rsp_grant,
    output logic                     rsp_room,
    output logic [ADDR_W-1:0]        rsp_vaddr,
    output logic                     rsp_locked,
    output logic                     err_flag
);
    localparam int SETS  = CAP_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [ADDR_W-1:0] tag_q    [SETS][WAYS];
    perm_e             perm_q   [SETS][WAYS];
    logic              lk_own_q [SETS][WAYS];
    logic [CTX_W-1:0]  lk_ctx_q [SETS][WAYS];

    op_e                       op;
    logic [SET_W-1:0]          set_idx;
    logic [WAYS-1:0][ADDR_W-1:0] row_tag;
    perm_e [WAYS-1:0]          row_perm;
    logic                      match_any, hit_any, free_any, room;
    logic [WAY_W-1:0]          match_way, hit_way, free_way, victim_way;
    logic                      illegal, legal, touch_en, grant;
    logic [WAY_W-1:0]          touch_way;
    perm_e                     hit_perm;

    assign op        = op_e'(req_op);
    assign set_idx   = req_addr[IDX_LO +: SET_W];
    assign req_ready = 1'b1;

    // gather the addressed set into packed rows for the comparator
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_tag[w]  = tag_q[set_idx][w];
            row_perm[w] = perm_q[set_idx][w];
        end
    end

    tagdir_way_cmp #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_cmp (
        .key       (req_addr),
        .row_tag   (row_tag),
        .row_perm  (row_perm),
        .match_any (match_any),
        .hit_any   (hit_any),
        .free_any  (free_any),
        .match_way (match_way),
        .hit_way   (hit_way),
        .free_way  (free_way)
    );

    assign room     = match_any | free_any;
    assign hit_perm = row_perm[hit_way];
    assign grant    = hit_any && ((hit_perm == PERM_RDWR) ||
                      ((hit_perm == PERM_RDONLY) && (req_kind != KIND_STORE)));

    // decide whether the request breaks a rule
    always_comb begin
        case (op)
            OP_LOOKUP, OP_PEEK, OP_ROOM: illegal = 1'b0;
            OP_ALLOC:                    illegal = hit_any || !free_any;
            OP_FREE:                     illegal = !hit_any;
            OP_VICTIM:                   illegal = room;
            OP_SETPERM:                  illegal = !match_any || (req_perm > 3'd5);
            OP_LKSET, OP_LKCLR, OP_LKTEST: illegal = !hit_any;
            default:                     illegal = 1'b1;
        endcase
    end

    assign legal     = req_valid && !illegal;
    assign touch_en  = legal && ((op == OP_LOOKUP && hit_any) || (op == OP_ALLOC && req_touch));
    assign touch_way = (op == OP_ALLOC) ? free_way : hit_way;

    tagdir_nru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_nru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_set  (set_idx),
        .touch_way  (touch_way),
        .rd_set     (set_idx),
        .victim_way (victim_way)
    );

    // apply the state change of a legal request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]    <= '0;
                    perm_q[s][w]   <= PERM_EMPTY;
                    lk_own_q[s][w] <= 1'b0;
                    lk_ctx_q[s][w] <= '0;
                end
        end else if (legal) begin
            case (op)
                OP_ALLOC: begin
                    tag_q[set_idx][free_way]    <= req_addr;
                    perm_q[set_idx][free_way]   <= PERM_INVALID;
                    lk_own_q[set_idx][free_way] <= 1'b0;
                end
                OP_FREE: begin
                    perm_q[set_idx][hit_way]   <= PERM_EMPTY;
                    lk_own_q[set_idx][hit_way] <= 1'b0;
                end
                OP_SETPERM: perm_q[set_idx][match_way] <= perm_e'(req_perm);
                OP_LKSET: begin
                    lk_own_q[set_idx][hit_way] <= 1'b1;
                    lk_ctx_q[set_idx][hit_way] <= req_ctx;
                end
                OP_LKCLR: lk_own_q[set_idx][hit_way] <= 1'b0;
                default: ;
            endcase
        end
    end

    // register the response fields one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_grant  <= 1'b0;
            rsp_room   <= 1'b0;
            rsp_vaddr  <= '0;
            rsp_locked <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= (op == OP_PEEK) ? match_any : hit_any;
            case (op)
                OP_PEEK:   rsp_way <= match_way;
                OP_ALLOC:  rsp_way <= free_way;
                OP_VICTIM: rsp_way <= victim_way;
                default:   rsp_way <= hit_way;
            endcase
            rsp_grant  <= (op == OP_LOOKUP) && grant;
            rsp_room   <= room;
            rsp_vaddr  <= (op == OP_VICTIM) ? row_tag[victim_way] : '0;
            rsp_locked <= (op == OP_LKTEST) && hit_any && lk_own_q[set_idx][hit_way] &&
                          (lk_ctx_q[set_idx][hit_way] == req_ctx);
        end
    end

    // hold the error flag once any illegal request arrives
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_flag <= 1'b0;
        else if (req_valid && illegal)  err_flag <= 1'b1;
    end

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R4
    grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> rsp_hit);

    // R10
    lock_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_locked) |-> rsp_hit);

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

endmodule

// File: tb/test_tagdir_top.sv
module test_tagdir_top;
    import tagdir_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_perm = '0;
    logic [3:0]  req_ctx = '0;
    logic        req_touch = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_grant, rsp_room, rsp_locked, err_flag;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_vaddr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tagdir_top i_tagdir_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm),
        .req_ctx(req_ctx), .req_touch(req_touch), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_grant(rsp_grant), .rsp_room(rsp_room),
        .rsp_vaddr(rsp_vaddr), .rsp_locked(rsp_locked), .err_flag(err_flag)
    );

    function automatic logic [31:0] mk(input int tag, input int set);
        return (32'(tag) << 8) | (32'(set) << 4);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input op_e op, input logic [31:0] addr, input logic [1:0] kind = 2'd0,
                         input logic [2:0] perm = 3'd0, input logic [3:0] ctx = 4'd0,
                         input logic touch = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_kind = kind;
        req_perm = perm; req_ctx = ctx; req_touch = touch;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic do_raw(input logic [3:0] code);
        @(negedge clk);
        req_valid = 1'b1; req_op = code; req_addr = '0;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        do_reset();
        chk("R1", "err after reset", err_flag, 0);
        do_op(OP_LOOKUP, mk(1, 0));
        chk("R1", "lookup miss", rsp_hit, 0);
        do_op(OP_ROOM, mk(1, 9));
        chk("R1", "room", rsp_room, 1);
    endtask

    task automatic t_handshake;
        chk("R12", "ready", req_ready, 1);
        do_op(OP_ROOM, mk(2, 2));
        chk("R12", "rsp_valid after req", rsp_valid, 1);
        @(posedge clk); #1;
        chk("R12", "rsp_valid idle", rsp_valid, 0);
    endtask

    task automatic t_alloc_lookup;
        do_op(OP_ALLOC, mk(1, 3));
        chk("R6", "first alloc way", rsp_way, 0);
        do_op(OP_ALLOC, mk(2, 3));
        chk("R6", "second alloc way", rsp_way, 1);
        do_op(OP_LOOKUP, mk(1, 3), KIND_LOAD);
        chk("R3", "lookup invalid hit", rsp_hit, 1);
        chk("R6", "alloc perm invalid no grant", rsp_grant, 0);
        do_op(OP_PEEK, mk(1, 3));
        chk("R3", "peek hit", rsp_hit, 1);
    endtask

    task automatic t_perm_grant;
        do_op(OP_SETPERM, mk(1, 3), 0, 3'd3);
        do_op(OP_LOOKUP, mk(1, 3), KIND_LOAD);
        chk("R4", "RO load grant", rsp_grant, 1);
        do_op(OP_LOOKUP, mk(1, 3), KIND_FETCH);
        chk("R4", "RO fetch grant", rsp_grant, 1);
        do_op(OP_LOOKUP, mk(1, 3), KIND_STORE);
        chk("R4", "RO store hit", rsp_hit, 1);
        chk("R4", "RO store refused", rsp_grant, 0);
        do_op(OP_SETPERM, mk(2, 3), 0, 3'd4);
        do_op(OP_LOOKUP, mk(2, 3), KIND_STORE);
        chk("R4", "RW store grant", rsp_grant, 1);
        do_op(OP_SETPERM, mk(2, 3), 0, 3'd5);
        do_op(OP_LOOKUP, mk(2, 3), KIND_LOAD);
        chk("R4", "busy not granted", rsp_grant, 0);
        do_op(OP_SETPERM, mk(2, 3), 0, 3'd1);
        do_op(OP_LOOKUP, mk(2, 3), KIND_LOAD);
        chk("R3", "notpresent lookup miss", rsp_hit, 0);
        do_op(OP_PEEK, mk(2, 3));
        chk("R3", "notpresent peek hit", rsp_hit, 1);
        chk("R3", "notpresent peek way", rsp_way, 1);
        do_op(OP_ROOM, mk(2, 3));
        chk("R5", "room on tag match", rsp_room, 1);
        do_op(OP_ALLOC, mk(3, 3));
        chk("R6", "alloc reuses notpresent way", rsp_way, 1);
        do_op(OP_PEEK, mk(2, 3));
        chk("R6", "replaced line gone", rsp_hit, 0);
    endtask

    task automatic t_index;
        do_op(OP_LOOKUP, mk(1, 4), KIND_LOAD);
        chk("R2", "same tag other set misses", rsp_hit, 0);
        do_op(OP_LOOKUP, mk(1, 3), KIND_LOAD);
        chk("R2", "own set hits", rsp_hit, 1);
    endtask

    task automatic t_victim_nru;
        for (int i = 0; i < 4; i++) do_op(OP_ALLOC, mk(10 + i, 5));
        do_op(OP_ROOM, mk(20, 5));
        chk("R5", "full set no room", rsp_room, 0);
        do_op(OP_ROOM, mk(11, 5));
        chk("R5", "full set room on match", rsp_room, 1);
        do_op(OP_VICTIM, mk(20, 5));
        chk("R8", "victim addr initial", rsp_vaddr, mk(10, 5));
        chk("R8", "victim way initial", rsp_way, 0);
        do_op(OP_LOOKUP, mk(10, 5), KIND_LOAD);
        do_op(OP_VICTIM, mk(20, 5));
        chk("R7", "victim after touch way0", rsp_vaddr, mk(11, 5));
        do_op(OP_LOOKUP, mk(11, 5), KIND_STORE);
        do_op(OP_LOOKUP, mk(12, 5), KIND_LOAD);
        do_op(OP_VICTIM, mk(20, 5));
        chk("R7", "refused hit still touches", rsp_vaddr, mk(13, 5));
        do_op(OP_LOOKUP, mk(13, 5), KIND_LOAD);
        do_op(OP_VICTIM, mk(20, 5));
        chk("R7", "saturation collapse", rsp_way, 0);
        chk("R8", "victim addr after collapse", rsp_vaddr, mk(10, 5));
        chk("R8", "no error on legal probes", err_flag, 0);
    endtask

    task automatic t_touch_alloc;
        do_op(OP_ALLOC, mk(30, 6), 0, 0, 0, 1'b1);
        for (int i = 1; i < 4; i++) do_op(OP_ALLOC, mk(30 + i, 6));
        do_op(OP_VICTIM, mk(40, 6));
        chk("R7", "alloc touch skips way0", rsp_vaddr, mk(31, 6));
    endtask

    task automatic t_dealloc;
        do_op(OP_FREE, mk(12, 5));
        do_op(OP_LOOKUP, mk(12, 5), KIND_LOAD);
        chk("R9", "freed line misses", rsp_hit, 0);
        do_op(OP_ROOM, mk(20, 5));
        chk("R9", "room after free", rsp_room, 1);
        do_op(OP_ALLOC, mk(20, 5));
        chk("R9", "alloc into freed way", rsp_way, 2);
    endtask

    task automatic t_lock;
        do_op(OP_LKSET, mk(1, 3), 0, 0, 4'd5);
        do_op(OP_LKTEST, mk(1, 3), 0, 0, 4'd5);
        chk("R10", "owner matches", rsp_locked, 1);
        do_op(OP_LKTEST, mk(1, 3), 0, 0, 4'd6);
        chk("R10", "other context", rsp_locked, 0);
        do_op(OP_LKCLR, mk(1, 3));
        do_op(OP_LKTEST, mk(1, 3), 0, 0, 4'd5);
        chk("R10", "cleared", rsp_locked, 0);
        do_op(OP_LKSET, mk(1, 3), 0, 0, 4'd5);
        do_op(OP_FREE, mk(1, 3));
        do_op(OP_ALLOC, mk(1, 3));
        chk("R6", "realloc way", rsp_way, 0);
        do_op(OP_LKTEST, mk(1, 3), 0, 0, 4'd5);
        chk("R6", "alloc releases lock", rsp_locked, 0);
        do_op(OP_LOOKUP, mk(1, 3), KIND_LOAD);
        chk("R6", "realloc perm invalid", rsp_grant, 0);
        chk("R11", "no error in legal sequence", err_flag, 0);
    endtask

    task automatic t_errors;
        do_reset();
        do_op(OP_ALLOC, mk(1, 8));
        do_op(OP_ALLOC, mk(1, 8));
        chk("R11", "alloc present flags", err_flag, 1);
        do_op(OP_PEEK, mk(1, 8));
        chk("R11", "no duplicate way", rsp_way, 0);
        do_op(OP_ALLOC, mk(2, 8));
        chk("R11", "duplicate did not take way1", rsp_way, 1);
        do_op(OP_ROOM, mk(9, 9));
        chk("R11", "error sticky", err_flag, 1);
        do_reset();
        chk("R1", "reset clears error", err_flag, 0);
        for (int i = 0; i < 4; i++) do_op(OP_ALLOC, mk(50 + i, 7));
        do_op(OP_ALLOC, mk(60, 7));
        chk("R11", "alloc full flags", err_flag, 1);
        do_op(OP_LOOKUP, mk(60, 7), KIND_LOAD);
        chk("R11", "full alloc not stored", rsp_hit, 0);
        do_reset();
        do_op(OP_VICTIM, mk(1, 1));
        chk("R11", "probe with room flags", err_flag, 1);
        do_reset();
        do_op(OP_FREE, mk(1, 1));
        chk("R11", "free absent flags", err_flag, 1);
        do_reset();
        do_op(OP_LKTEST, mk(1, 1), 0, 0, 4'd0);
        chk("R11", "lock absent flags", err_flag, 1);
        chk("R10", "absent never locked", rsp_locked, 0);
        do_reset();
        do_op(OP_SETPERM, mk(1, 1), 0, 3'd4);
        chk("R11", "setperm absent flags", err_flag, 1);
        do_op(OP_LOOKUP, mk(1, 1), KIND_LOAD);
        chk("R11", "setperm absent no state", rsp_hit, 0);
        do_reset();
        do_raw(4'd12);
        chk("R11", "bad opcode flags", err_flag, 1);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_handshake();
        t_alloc_lookup();
        t_perm_grant();
        t_index();
        t_victim_nru();
        t_touch_alloc();
        t_dealloc();
        t_lock();
        t_errors();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule